// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block derives several related clocks from one fast synchronous source. A shared prescaler divides the source by one or by two, and four dividers count its ticks. Bank A, bank B and bank C each drive four outputs, and the feedback output is a single line. Each of the four has its own table of even ratios, picked by its select pins. Every divider gives a 50% duty cycle. All four start together, so their rising edges meet at the common multiples of their periods.

One active-low input serves as both reset and output enable. While it is low, every counter is cleared and every output floats. When it goes high, all banks start in phase on the first prescaled tick. A polarity pin can invert the upper two bank C outputs. A new ratio on a select input waits until that divider ends its current period, so no output ever produces a short pulse.

Top module: `bank_clk_divider`

## Requirements
- R1: With `pre_full` high the dividers advance on every `clk` edge. With it low they advance on every second edge, so each output period is twice as long.
- R2: Bank A ratio by `sel_a`: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 12 prescaled ticks per period.
- R3: Bank B ratio by `sel_b`: 0 gives 4, 1 gives 6, 2 gives 8, 3 gives 10.
- R4: Bank C ratio by `sel_c`: 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8.
- R5: Feedback ratio by `sel_fb`: 0 through 7 give 4, 6, 8, 10, 8, 12, 16, 20.
- R6: While `rst_oe_n` is low, all outputs are high-impedance (never driven high) and all counters are cleared.
- R7: `qc[1:0]` carry the bank C clock. `qc[3:2]` carry the same clock when `c_pol_n` is high and its complement when `c_pol_n` is low.
- R8: After `rst_oe_n` rises, every divider output goes high on the first prescaled tick: one `clk` edge later with `pre_full` high, and two edges later with it low.
- R9: A change on a select input takes effect only when that divider's current period ends. The period in progress keeps its old length and high time.
- R10: The outputs of one bank are identical on every cycle.
- R11: Each divider output is high for the first half of its period and low for the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_oe_n | input | 1 | Active-low reset; high enables outputs |
| pre_full | input | 1 | Prescaler: 1 = divide by 1, 0 = divide by 2 |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| c_pol_n | input | 1 | Low inverts qc[3:2] |
| qa | output | 4 | Bank A clocks |
| qb | output | 4 | Bank B clocks |
| qc | output | 4 | Bank C clocks |
| qfb | output | 1 | Feedback clock |

## Verification
The hardest case to reach is a select change that arrives partway through a long period. The divider must finish that period with the old ratio, and the error only shows several ticks later. The stimulus changes every select at uneven moments while the outputs are running. It does this once with the prescaler at one and once at two. The reference model decides on every clock edge whether a new ratio may be loaded, so a divider that applies a change too early is caught on the first cycle where its output differs.

// File: rtl/bank_clk_divider.sv
module bank_clk_divider #(
  parameter int CNT_W = 5,
  parameter int BANK_W = 4,
  parameter logic [BANK_W-1:0] INV_MASK = 4'b1100
) (
  input  logic              clk,
  input  logic              rst_oe_n,
  input  logic              pre_full,
  input  logic [1:0]        sel_a,
  input  logic [1:0]        sel_b,
  input  logic [1:0]        sel_c,
  input  logic [2:0]        sel_fb,
  input  logic              c_pol_n,
  output wire  [BANK_W-1:0] qa,
  output wire  [BANK_W-1:0] qb,
  output wire  [BANK_W-1:0] qc,
  output wire               qfb
);
  localparam int NDIV = 4;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ph;
  logic tick;
  logic [CNT_W-1:0] rat [NDIV];
  logic q [NDIV];

  always_ff @(posedge clk or negedge rst_oe_n)
    if (!rst_oe_n) ph <= 1'b0;
    else           ph <= ~ph;

  assign tick = pre_full | ph;

  always_comb begin
    case (sel_a)
      2'd0: rat[0] = CNT_W'(4);
      2'd1: rat[0] = CNT_W'(6);
      2'd2: rat[0] = CNT_W'(8);
      default: rat[0] = CNT_W'(12);
    endcase
    case (sel_b)
      2'd0: rat[1] = CNT_W'(4);
      2'd1: rat[1] = CNT_W'(6);
      2'd2: rat[1] = CNT_W'(8);
      default: rat[1] = CNT_W'(10);
    endcase
    rat[2] = CNT_W'({sel_c, 1'b0}) + CNT_W'(2);
    case (sel_fb)
      3'd0: rat[3] = CNT_W'(4);
      3'd1: rat[3] = CNT_W'(6);
      3'd2: rat[3] = CNT_W'(8);
      3'd3: rat[3] = CNT_W'(10);
      3'd4: rat[3] = CNT_W'(8);
      3'd5: rat[3] = CNT_W'(12);
      3'd6: rat[3] = CNT_W'(16);
      default: rat[3] = CNT_W'(20);
    endcase
  end

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    logic [CNT_W-1:0] cnt, len;
    logic run, q_r;
    always_ff @(posedge clk or negedge rst_oe_n)
      if (!rst_oe_n) begin
        cnt <= '0;
        len <= '0;
        run <= 1'b0;
        q_r <= 1'b0;
      end else if (tick) begin
        if (!run || cnt == len - ONE) begin
          run <= 1'b1;
          cnt <= '0;
          len <= rat[g];
          q_r <= 1'b1;
        end else begin
          cnt <= cnt + ONE;
          q_r <= (cnt + ONE) < (len >> 1);
        end
      end
    assign q[g] = q_r;
  end

  for (genvar i = 0; i < BANK_W; i++) begin : g_out
    assign qa[i] = rst_oe_n ? q[0] : 1'bz;
    assign qb[i] = rst_oe_n ? q[1] : 1'bz;
    assign qc[i] = rst_oe_n ? (q[2] ^ (INV_MASK[i] & ~c_pol_n)) : 1'bz;
  end
  assign qfb = rst_oe_n ? q[3] : 1'bz;
endmodule

// File: rtl/bank_clk_divider_chk.sv
module bank_clk_divider_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_oe_n,
  input logic              pre_full,
  input logic              c_pol_n,
  input logic [BANK_W-1:0] qa,
  input logic [BANK_W-1:0] qb,
  input logic [BANK_W-1:0] qc,
  input logic              qfb
);
  a_r8_first_tick_high: assert property (@(posedge clk) disable iff (!rst_oe_n)
    ($rose(rst_oe_n) && pre_full) |=> (qa[0] && qb[0] && qc[0] && qfb));

  a_r10_bank_uniform: assert property (@(posedge clk) disable iff (!rst_oe_n)
    rst_oe_n |-> ((qa == '0 || qa == '1) && (qb == '0 || qb == '1)));

  a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_oe_n)
    rst_oe_n |-> (qc[3] == (c_pol_n ? qc[1] : ~qc[1])) && (qc[0] == qc[1]));

  a_r1_slow_hold: assert property (@(posedge clk) disable iff (!rst_oe_n)
    (!pre_full && !$past(pre_full) && $past(rst_oe_n) && (qc[0] != $past(qc[0])))
      |=> $stable(qc[0]));
endmodule

bind bank_clk_divider bank_clk_divider_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_oe_n(rst_oe_n), .pre_full(pre_full), .c_pol_n(c_pol_n),
  .qa(qa), .qb(qb), .qc(qc), .qfb(qfb));

// File: tb/sim_bank_clk_divider.sv
module sim_bank_clk_divider;
  localparam int CLK_T = 10;

  logic clk = 1'b0;
  logic rst_oe_n = 1'b0;
  logic pre_full = 1'b1;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0] sel_fb = '0;
  logic c_pol_n = 1'b1;
  wire [3:0] qa, qb, qc;
  wire qfb;

  int errs = 0, checks = 0;
  bit done = 0;
  string scen = "base";

  bank_clk_divider u0 (.clk(clk), .rst_oe_n(rst_oe_n), .pre_full(pre_full),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
    .c_pol_n(c_pol_n), .qa(qa), .qb(qb), .qc(qc), .qfb(qfb));

  always #(CLK_T/2) clk = ~clk;

  // behavioural reference
  bit m_ph = 0;
  int m_pos [4];
  int m_len [4];
  bit m_run [4];
  bit m_q [4];

  function automatic int want_len(int ch);
    int t_a [4] = '{4, 6, 8, 12};
    int t_b [4] = '{4, 6, 8, 10};
    int t_f [8] = '{4, 6, 8, 10, 8, 12, 16, 20};
    case (ch)
      0: return t_a[sel_a];
      1: return t_b[sel_b];
      2: return 2 * (int'(sel_c) + 1);
      default: return t_f[sel_fb];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_oe_n) begin
      m_ph = 0;
      for (int c = 0; c < 4; c++) begin
        m_pos[c] = 0; m_len[c] = 0; m_run[c] = 0; m_q[c] = 0;
      end
    end else begin
      bit adv;
      adv = pre_full || m_ph;
      m_ph = !m_ph;
      if (adv)
        for (int c = 0; c < 4; c++) begin
          if (!m_run[c] || m_pos[c] == m_len[c] - 1) begin
            m_run[c] = 1; m_pos[c] = 0; m_len[c] = want_len(c); m_q[c] = 1;
          end else begin
            m_pos[c]++;
            m_q[c] = (m_pos[c] < m_len[c] / 2);
          end
        end
    end
  end

  task automatic chk(bit ok, string tag, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s [%s] t=%0t: got %b expected %b", tag, scen, $time, got, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    if (!rst_oe_n) begin
      chk(qa === 4'bzzzz || qa === 4'b0000, "R6", qa, 4'b0000);
      chk(qc === 4'bzzzz || qc === 4'b0000, "R6", qc, 4'b0000);
      chk(qfb !== 1'b1, "R6", {3'b0, qfb}, 4'b0000);
    end else begin
      logic [3:0] ec;
      ec = {{2{m_q[2] ^ !c_pol_n}}, {2{m_q[2]}}};
      chk(qa === {4{m_q[0]}}, "R2 R11", qa, {4{m_q[0]}});
      chk(qb === {4{m_q[1]}}, "R3 R11", qb, {4{m_q[1]}});
      chk(qc[1:0] === ec[1:0], "R4 R11", qc, ec);
      chk(qc[3:2] === ec[3:2], "R7", qc, ec);
      chk(qfb === m_q[3], "R5 R11", {3'b0, qfb}, {3'b0, m_q[3]});
      chk(qa === 4'b0000 || qa === 4'b1111, "R10", qa, {4{qa[0]}});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic restart(bit pf);
    rst_oe_n = 0;
    cyc(2);
    pre_full = pf;
    rst_oe_n = 1;
  endtask

  initial begin
    #(CLK_T * 200000);
    errs++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int prev, rises [$];
    cyc(3);
    // R1 and R8: period and first edge of fastest bank
    for (int p = 1; p >= 0; p--) begin
      scen = "R1";
      sel_c = 0;
      restart(p[0]);
      cyc(1);
      chk(qc[0] === (p == 1), "R8", {3'b0, qc[0]}, {3'b0, p == 1});
      cyc(1);
      chk(qa[0] === 1'b1 && qfb === 1'b1, "R8", {2'b0, qa[0], qfb}, 4'b0011);
      rises.delete();
      prev = qc[0];
      for (int k = 0; k < 24; k++) begin
        cyc(1);
        if (qc[0] === 1'b1 && prev == 0) rises.push_back(k);
        prev = qc[0];
      end
      chk(rises.size() >= 2 && rises[1] - rises[0] == (p == 1 ? 2 : 4), "R1",
          4'(rises[1] - rises[0]), (p == 1 ? 4'd2 : 4'd4));
    end
    // all ratio codes, both prescaler settings
    for (int p = 1; p >= 0; p--)
      for (int c = 0; c < 8; c++) begin
        scen = "ratios";
        sel_a = 2'(c); sel_b = 2'(3 - c); sel_c = 2'(c + 1); sel_fb = 3'(c);
        c_pol_n = c[0];
        restart(p[0]);
        cyc(90);
      end
    // mid-period select and polarity changes
    for (int p = 1; p >= 0; p--) begin
      scen = "R9";
      sel_a = 3; sel_b = 3; sel_c = 3; sel_fb = 7;
      restart(p[0]);
      for (int k = 0; k < 12; k++) begin
        cyc(3 + (k % 5) * 2);
        sel_a = 2'(k); sel_b = 2'(k + 1); sel_c = 2'(k + 2); sel_fb = 3'(k * 3);
        if (k % 3 == 0) c_pol_n = !c_pol_n;
      end
      cyc(60);
    end
    // reset while running
    scen = "R6";
    cyc(5);
    rst_oe_n = 0;
    cyc(4);
    rst_oe_n = 1;
    cyc(40);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule